// File: doc/BRIEF.md
# Paired-Channel Compare Reference Generator

This block produces the output-compare reference levels for two timer channels that share one up/down counter. Each cycle it compares the shared count against each channel's compare value. It then applies that channel's 4-bit mode code and registers the result as the channel reference. The counter, prescaler, dead-time, polarity and register access all sit outside this block. Mode codes arrive already assembled as 4-bit values.

Each channel also drives a combined reference. In most modes the combined reference copies the channel's own reference. In the combined modes it is the OR or the AND of both channel references. In the asymmetric modes it takes the first channel's reference while counting up and the second channel's reference while counting down. Two retriggerable one-pulse modes are supported: a trigger arms the compare and the next update event ends it.

Top module: `ocref_pair`

## Requirements
- R1: While rst_ni is low, every output is 0 (inactive).
- R2: Code 0 holds the reference at its last value. Code 4 forces it to 0 and code 5 forces it to 1.
- R3: When the count equals the compare value, code 1 sets the reference to 1, code 2 clears it to 0 and code 3 inverts it. When the count does not equal the compare value, these codes hold the reference.
- R4: Code 6 (PWM A) gives 1 when counting up with count < compare, and 1 when counting down with count <= compare. It gives 0 otherwise.
- R5: Code 7 (PWM B) gives the complement of PWM A for the same count, compare value and direction.
- R6: Code 8 when counting up: the reference is 1 until a trigger arrives. After the trigger it follows PWM A. An update event returns it to 1 and it stays 1 until the next trigger.
- R7: Code 9 when counting up: the reference is 0 until a trigger arrives. After the trigger it follows PWM B. An update event returns it to 0.
- R8: When counting down, the waiting levels swap: code 8 waits at 0 and code 9 waits at 1. The trigger and update rules are the same as when counting up.
- R9: If a trigger and an update arrive in the same cycle, the trigger wins and the pulse runs. Leaving codes 8 and 9 disarms the pulse.
- R10: The reserved codes 10 and 11 drive the reference to 0.
- R11: For codes 12 to 15 the channel reference behaves as PWM A (codes 12 and 14) or PWM B (codes 13 and 15). The combined reference is the OR of both channel references for code 12 and the AND of both for code 13.
- R12: For codes 14 and 15 the combined reference equals channel 1's reference when counting up and channel 2's reference when counting down. For codes 0 to 11 it equals the channel's own reference.
- R13: All outputs are registered. A change on any input shows at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared counter value |
| down_i | input | 1 | Counting direction, 1 = down |
| upd_i | input | 1 | Update event pulse |
| trig_i | input | 1 | Trigger pulse |
| cmp1_i | input | CNT_W | Channel 1 compare value |
| cmp2_i | input | CNT_W | Channel 2 compare value |
| mode1_i | input | 4 | Channel 1 mode code |
| mode2_i | input | 4 | Channel 2 mode code |
| ref1_o | output | 1 | Channel 1 reference |
| ref2_o | output | 1 | Channel 2 reference |
| refc1_o | output | 1 | Channel 1 combined reference |
| refc2_o | output | 1 | Channel 2 combined reference |

## Verification
The assertions assume that the count, direction, mode and compare inputs hold steady across each clock edge. They also assume that trigger and update are single-cycle levels sampled at that edge. The implications are written so that only the mode present at the edge matters, so a mode change between cycles is legal. The bench changes inputs only one time unit after a rising edge and reads outputs just after the following edge. Each scenario moves the counter directly to the values of interest instead of sweeping it.

// File: rtl/ocref_pkg.sv
package ocref_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [3:0] {
    OC_FROZEN  = 4'd0,
    OC_SET_EQ  = 4'd1,
    OC_CLR_EQ  = 4'd2,
    OC_TOG_EQ  = 4'd3,
    OC_LOW     = 4'd4,
    OC_HIGH    = 4'd5,
    OC_PWM_A   = 4'd6,
    OC_PWM_B   = 4'd7,
    OC_OPM_A   = 4'd8,
    OC_OPM_B   = 4'd9,
    OC_RSV_A   = 4'd10,
    OC_RSV_B   = 4'd11,
    OC_OR_A    = 4'd12,
    OC_AND_B   = 4'd13,
    OC_ASYM_A  = 4'd14,
    OC_ASYM_B  = 4'd15
  } oc_mode_e;
endpackage

// File: rtl/ocref_chan.sv
module ocref_chan import ocref_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             down_i,
  input  logic             upd_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [3:0]       mode_i,
  output logic             ref_d_o,
  output logic             ref_q_o
);
  oc_mode_e mode;
  logic     eq, pwm_a, is_opm, run_d, run_q, wait_lvl, ref_d;

  assign mode  = oc_mode_e'(mode_i);
  assign eq    = (cnt_i == cmp_i);
  // up: active below compare; down: inactive only above compare
  assign pwm_a = down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);

  assign is_opm   = (mode == OC_OPM_A) || (mode == OC_OPM_B);
  assign wait_lvl = (mode == OC_OPM_A) ^ down_i;

  always_comb begin
    if (!is_opm)     run_d = 1'b0;
    else if (trig_i) run_d = 1'b1;
    else if (upd_i)  run_d = 1'b0;
    else             run_d = run_q;
  end

  always_comb begin
    unique case (mode)
      OC_FROZEN:                     ref_d = ref_q_o;
      OC_SET_EQ:                     ref_d = eq ? 1'b1 : ref_q_o;
      OC_CLR_EQ:                     ref_d = eq ? 1'b0 : ref_q_o;
      OC_TOG_EQ:                     ref_d = eq ? ~ref_q_o : ref_q_o;
      OC_LOW:                        ref_d = 1'b0;
      OC_HIGH:                       ref_d = 1'b1;
      OC_PWM_A, OC_OR_A, OC_ASYM_A:  ref_d = pwm_a;
      OC_PWM_B, OC_AND_B, OC_ASYM_B: ref_d = ~pwm_a;
      OC_OPM_A:                      ref_d = run_d ? pwm_a : wait_lvl;
      OC_OPM_B:                      ref_d = run_d ? ~pwm_a : wait_lvl;
      default:                       ref_d = 1'b0;
    endcase
  end

  assign ref_d_o = ref_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q_o <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      ref_q_o <= ref_d;
      run_q   <= run_d;
    end
  end

  a_r2_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd0) |=> $stable(ref_q_o));
  a_r2_force_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd4) |=> !ref_q_o);
  a_r2_force_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd5) |=> ref_q_o);
  a_r3_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd3 && cnt_i == cmp_i) |=> (ref_q_o != $past(ref_q_o)));
  a_r4_pwm_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd6 && !down_i && cnt_i < cmp_i) |=> ref_q_o);
  a_r6_upd_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd8 && !down_i && upd_i && !trig_i) |=> ref_q_o);
  a_r10_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd10 || mode_i == 4'd11) |=> !ref_q_o);
endmodule

// File: rtl/ocref_comb.sv
module ocref_comb import ocref_pkg::*; #(
  parameter int unsigned IDX = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           down_i,
  input  logic [3:0]     mode_i,
  input  logic [NCH-1:0] ref_d_i,
  input  logic [NCH-1:0] ref_q_i,
  output logic           refc_o
);
  localparam int unsigned OTH = NCH - 1 - IDX;

  oc_mode_e mode;
  logic     refc_d;

  assign mode = oc_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      OC_OR_A:              refc_d = ref_d_i[IDX] | ref_d_i[OTH];
      OC_AND_B:             refc_d = ref_d_i[IDX] & ref_d_i[OTH];
      OC_ASYM_A, OC_ASYM_B: refc_d = down_i ? ref_d_i[1] : ref_d_i[0];
      default:              refc_d = ref_d_i[IDX];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refc_o <= 1'b0;
    else         refc_o <= refc_d;
  end

  a_r11_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd12) |=> (refc_o == (ref_q_i[0] | ref_q_i[1])));
  a_r11_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd13) |=> (refc_o == (ref_q_i[0] & ref_q_i[1])));
  a_r12_asym_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[3:1] == 3'b111 && !down_i) |=> (refc_o == ref_q_i[0]));
  a_r12_asym_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[3:1] == 3'b111 && down_i) |=> (refc_o == ref_q_i[1]));
  a_r12_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i < 4'd12) |=> (refc_o == ref_q_i[IDX]));
endmodule

// File: rtl/ocref_pair.sv
module ocref_pair import ocref_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             down_i,
  input  logic             upd_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [CNT_W-1:0] cmp2_i,
  input  logic [3:0]       mode1_i,
  input  logic [3:0]       mode2_i,
  output logic             ref1_o,
  output logic             ref2_o,
  output logic             refc1_o,
  output logic             refc2_o
);
  logic [CNT_W-1:0] cmp_arr  [NCH];
  logic [3:0]       mode_arr [NCH];
  logic [NCH-1:0]   ref_d, ref_q, refc;

  assign cmp_arr[0]  = cmp1_i;
  assign cmp_arr[1]  = cmp2_i;
  assign mode_arr[0] = mode1_i;
  assign mode_arr[1] = mode2_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ocref_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt_i),
      .down_i  (down_i),
      .upd_i   (upd_i),
      .trig_i  (trig_i),
      .cmp_i   (cmp_arr[g]),
      .mode_i  (mode_arr[g]),
      .ref_d_o (ref_d[g]),
      .ref_q_o (ref_q[g])
    );

    ocref_comb #(.IDX(g)) u_comb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .down_i  (down_i),
      .mode_i  (mode_arr[g]),
      .ref_d_i (ref_d),
      .ref_q_i (ref_q),
      .refc_o  (refc[g])
    );
  end

  assign ref1_o  = ref_q[0];
  assign ref2_o  = ref_q[1];
  assign refc1_o = refc[0];
  assign refc2_o = refc[1];

  a_r1_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (ref_q == '0 && refc == '0));
endmodule

// File: tb/tb_ocref_pair.sv
module tb_ocref_pair;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             down_i = 1'b0, upd_i = 1'b0, trig_i = 1'b0;
  logic [CNT_W-1:0] cmp1_i = '0, cmp2_i = '0;
  logic [3:0]       mode1_i = 4'd0, mode2_i = 4'd0;
  logic             ref1_o, ref2_o, refc1_o, refc2_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  ocref_pair #(.CNT_W(CNT_W)) dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ref1", ref1_o, 1'b0);
    chk("R1 ref2", ref2_o, 1'b0);
    chk("R1 refc1", refc1_o, 1'b0);
    chk("R1 refc2", refc2_o, 1'b0);
    step(); rst_ni = 1'b1; step();
  endtask

  task automatic t_force();
    cnt_i = 16'd3; cmp1_i = 16'd10; mode1_i = 4'd5;
    #2 chk("R13 no early change", ref1_o, 1'b0);
    step(); chk("R2 force high", ref1_o, 1'b1);
    mode1_i = 4'd0; cnt_i = 16'd10; step(); chk("R2 frozen holds 1", ref1_o, 1'b1);
    mode1_i = 4'd4; step(); chk("R2 force low", ref1_o, 1'b0);
    mode1_i = 4'd0; cnt_i = 16'd2; step(); chk("R2 frozen holds 0", ref1_o, 1'b0);
  endtask

  task automatic t_match();
    cmp1_i = 16'd10; mode1_i = 4'd1; cnt_i = 16'd5;
    step(); chk("R3 set no match", ref1_o, 1'b0);
    cnt_i = 16'd10; step(); chk("R3 set on match", ref1_o, 1'b1);
    cnt_i = 16'd11; step(); chk("R3 set holds", ref1_o, 1'b1);
    mode1_i = 4'd2; cnt_i = 16'd10; step(); chk("R3 clear on match", ref1_o, 1'b0);
    mode1_i = 4'd3; step(); chk("R3 toggle first", ref1_o, 1'b1);
    step(); chk("R3 toggle second", ref1_o, 1'b0);
    cnt_i = 16'd3; step(); chk("R3 toggle holds", ref1_o, 1'b0);
  endtask

  task automatic t_pwm();
    cmp1_i = 16'd10; mode1_i = 4'd6; down_i = 1'b0;
    cnt_i = 16'd9;  step(); chk("R4 up below", ref1_o, 1'b1);
    chk("R12 own copy", refc1_o, 1'b1);
    cnt_i = 16'd10; step(); chk("R4 up equal", ref1_o, 1'b0);
    down_i = 1'b1;
    cnt_i = 16'd10; step(); chk("R4 down equal", ref1_o, 1'b1);
    cnt_i = 16'd11; step(); chk("R4 down above", ref1_o, 1'b0);
    mode1_i = 4'd7; step(); chk("R5 pwm b down above", ref1_o, 1'b1);
    down_i = 1'b0; cnt_i = 16'd9; step(); chk("R5 pwm b up below", ref1_o, 1'b0);
  endtask

  task automatic t_opm_up();
    mode1_i = 4'd4; step();
    cmp1_i = 16'd10; down_i = 1'b0; mode1_i = 4'd8;
    cnt_i = 16'd5;  step(); chk("R6 waits high", ref1_o, 1'b1);
    cnt_i = 16'd15; step(); chk("R6 ignores compare", ref1_o, 1'b1);
    trig_i = 1'b1;  step(); chk("R6 triggered", ref1_o, 1'b0);
    trig_i = 1'b0; cnt_i = 16'd5; step(); chk("R6 follows pwm", ref1_o, 1'b1);
    cnt_i = 16'd15; step(); chk("R6 follows pwm above", ref1_o, 1'b0);
    upd_i = 1'b1;   step(); chk("R6 update rearms", ref1_o, 1'b1);
    upd_i = 1'b0;   step(); chk("R6 stays waiting", ref1_o, 1'b1);
    mode1_i = 4'd4; step();
    mode1_i = 4'd9; step(); chk("R7 waits low", ref1_o, 1'b0);
    trig_i = 1'b1;  step(); chk("R7 triggered", ref1_o, 1'b1);
    trig_i = 1'b0; cnt_i = 16'd5; step(); chk("R7 follows pwm b", ref1_o, 1'b0);
    cnt_i = 16'd15; upd_i = 1'b1; step(); chk("R7 update rearms", ref1_o, 1'b0);
    upd_i = 1'b0;
  endtask

  task automatic t_opm_down();
    mode1_i = 4'd4; step();
    cmp1_i = 16'd10; down_i = 1'b1; cnt_i = 16'd5; mode1_i = 4'd8;
    step(); chk("R8 mode 8 waits low", ref1_o, 1'b0);
    trig_i = 1'b1; step(); chk("R8 mode 8 triggered", ref1_o, 1'b1);
    trig_i = 1'b0; upd_i = 1'b1; step(); chk("R8 mode 8 update", ref1_o, 1'b0);
    upd_i = 1'b0; mode1_i = 4'd4; step();
    mode1_i = 4'd9; step(); chk("R8 mode 9 waits high", ref1_o, 1'b1);
    trig_i = 1'b1; step(); chk("R8 mode 9 triggered", ref1_o, 1'b0);
    trig_i = 1'b0; down_i = 1'b0;
  endtask

  task automatic t_trig_upd();
    mode1_i = 4'd4; step();
    cmp1_i = 16'd10; cnt_i = 16'd15; mode1_i = 4'd8;
    trig_i = 1'b1; upd_i = 1'b1; step(); chk("R9 trigger wins", ref1_o, 1'b0);
    trig_i = 1'b0; upd_i = 1'b0; step(); chk("R9 stays running", ref1_o, 1'b0);
    mode1_i = 4'd6; step();
    mode1_i = 4'd8; step(); chk("R9 mode exit disarms", ref1_o, 1'b1);
  endtask

  task automatic t_reserved();
    mode1_i = 4'd5; step();
    mode1_i = 4'd10; step(); chk("R10 code 10", ref1_o, 1'b0);
    mode1_i = 4'd5; step();
    mode1_i = 4'd11; step(); chk("R10 code 11", ref1_o, 1'b0);
  endtask

  task automatic t_comb();
    down_i = 1'b0; cmp1_i = 16'd10; cmp2_i = 16'd20;
    mode1_i = 4'd12; mode2_i = 4'd6;
    cnt_i = 16'd15; step();
    chk("R11 mode 12 ref is pwm a", ref1_o, 1'b0);
    chk("R11 or one high", refc1_o, 1'b1);
    cnt_i = 16'd25; step(); chk("R11 or both low", refc1_o, 1'b0);
    mode1_i = 4'd13; cnt_i = 16'd15; step();
    chk("R11 mode 13 ref is pwm b", ref1_o, 1'b1);
    chk("R11 and both high", refc1_o, 1'b1);
    cnt_i = 16'd5; step(); chk("R11 and one low", refc1_o, 1'b0);
  endtask

  task automatic t_asym();
    cmp1_i = 16'd10; cmp2_i = 16'd20; mode1_i = 4'd14; mode2_i = 4'd7;
    down_i = 1'b0; cnt_i = 16'd5; step();
    chk("R12 asym up ch1", refc1_o, 1'b1);
    chk("R12 ch2 own in pwm b", refc2_o, 1'b0);
    down_i = 1'b1; step(); chk("R12 asym down ch2 low", refc1_o, 1'b0);
    cnt_i = 16'd25; step(); chk("R12 asym down ch2 high", refc1_o, 1'b1);
    chk("R12 ch1 ref low", ref1_o, 1'b0);
    mode1_i = 4'd15; mode2_i = 4'd4; down_i = 1'b0; step();
    chk("R12 mode 15 up ch1", refc1_o, 1'b1);
    down_i = 1'b1; step(); chk("R12 mode 15 down ch2", refc1_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_force();
    t_match();
    t_pwm();
    t_opm_up();
    t_opm_down();
    t_trig_upd();
    t_reserved();
    t_comb();
    t_asym();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule